// File: doc/BRIEF.md
# Bus Address and Data Break Comparator

This block watches every completed access on a 16-bit CPU bus. When an access matches a programmed break address, it raises a break flag and an interrupt request. The match can also require the access to be of a chosen kind and to carry a chosen data value. Software programs the break address, a break data value, and a control word through a small register port. It then sees the sticky break flag in a status register.

The data compare follows the byte lanes the bus really uses. A byte access always carries its data on the upper lane, whether its address is even or odd, so a byte compare looks only at the upper byte of the break data. A word access at an even address carries both bytes, so both are compared. A word access at an odd address is compared on the lower lane only. The request line is the flag gated by its enable bit and nothing else, so it cannot be masked by the CPU's global interrupt-disable bit. The CPU's exception sequencing lies outside this block.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, the break address reads 0xFFFF, the control register reads 0, the status register reads 0, and `brk_flag` and `brk_irq` are 0. The break data register has no defined reset value.
- R2: With the access kind set to 0 (execute), only a cycle that has `bus_valid`=1 and `bus_fetch`=1, and whose address equals the break address, sets the flag. Here the address is the first byte of the instruction. Non-fetch accesses and other addresses do not set it.
- R3: Access kind 1 breaks on data reads (`bus_fetch`=0, `bus_write`=0). Kind 2 breaks on data writes (`bus_fetch`=0, `bus_write`=1). Kind 3 breaks on either. None of these three kinds breaks on a fetch.
- R4: With the data-compare enable (control bit 2) at 0, an address and kind match alone sets the flag, whatever the bus data.
- R5: With data compare on, a byte access (`bus_word`=0) matches when `bus_data[15:8]` equals break-data bits [15:8]. This holds for even and odd addresses alike, and `bus_data[7:0]` is ignored.
- R6: With data compare on, a word access (`bus_word`=1) at an even address needs all 16 bits to match. At an odd address it needs only `bus_data[7:0]` to equal break-data bits [7:0].
- R7: The flag is sticky. Writing status bit 0 as 0 clears it. Writing it as 1 has no effect, whether the flag is set or clear.
- R8: If a break match and a clearing status write fall in the same cycle, the flag ends up set.
- R9: `brk_irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit 3) is 1. No other input masks it.
- R10: Register select `cfg_sel` picks the register: 0 is the break address, 1 the break data, 2 the control register (bits [1:0] access kind, bit 2 data-compare enable, bit 3 interrupt enable), and 3 the status register (bit 0 flag). Written values read back on `cfg_rdata`.
- R11: A match sampled at a rising clock edge shows on `brk_flag` right after that edge, and not before it.
- R12: A cycle with `bus_valid`=0 never sets the flag, even when every other input matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 2 | Register select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| bus_valid | input | 1 | A bus access completes this cycle |
| bus_addr | input | 16 | Access address |
| bus_data | input | 16 | Access data, both byte lanes |
| bus_word | input | 1 | 1 for a word access, 0 for a byte access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_fetch | input | 1 | 1 when the access is an instruction fetch for execution |
| brk_flag | output | 1 | Sticky break flag |
| brk_irq | output | 1 | Break interrupt request |

## Verification
The hardest case to reach is a break match in the same cycle as a software clear. The register write and the bus access come from separate ports and must be lined up on one edge. The bench has a driver task that raises the status write and the matching access on the same falling edge, and the scoreboard then expects the flag to stay set. The lane choice is also hard to cover, because it depends on both size and address parity. It is exercised by pairs of accesses that differ only in the lane that should be ignored.

// File: rtl/bus_break_unit.sv
module bus_break_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cfg_sel,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         bus_valid,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  logic         bus_word,
  input  logic         bus_write,
  input  logic         bus_fetch,
  output logic         brk_flag,
  output logic         brk_irq
);
  localparam int BW = W / 2;

  logic [W-1:0] brk_addr, brk_data;
  logic [1:0]   kind;
  logic         dce, ie, flag;

  wire wr_addr = cfg_wr && cfg_sel == 2'd0;
  wire wr_data = cfg_wr && cfg_sel == 2'd1;
  wire wr_ctrl = cfg_wr && cfg_sel == 2'd2;
  wire clr     = cfg_wr && cfg_sel == 2'd3 && !cfg_wdata[0];

  wire hi_eq = bus_data[W-1:BW] == brk_data[W-1:BW];
  wire lo_eq = bus_data[BW-1:0] == brk_data[BW-1:0];
  wire data_ok = !bus_word ? hi_eq : (bus_addr[0] ? lo_eq : (hi_eq && lo_eq));

  logic kind_ok;
  always_comb begin
    case (kind)
      2'd0:    kind_ok = bus_fetch;
      2'd1:    kind_ok = !bus_fetch && !bus_write;
      2'd2:    kind_ok = !bus_fetch && bus_write;
      default: kind_ok = !bus_fetch;
    endcase
  end

  wire hit = bus_valid && bus_addr == brk_addr && kind_ok && (!dce || data_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '1;
      kind     <= 2'd0;
      dce      <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (wr_addr) brk_addr <= cfg_wdata;
      if (wr_ctrl) {ie, dce, kind} <= cfg_wdata[3:0];
      flag <= hit || (flag && !clr);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_data) brk_data <= cfg_wdata;
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = brk_addr;
      2'd1:    cfg_rdata = brk_data;
      2'd2:    cfg_rdata = {{(W-4){1'b0}}, ie, dce, kind};
      default: cfg_rdata = {{(W-1){1'b0}}, flag};
    endcase
  end

  assign brk_flag = flag;
  assign brk_irq  = flag && ie;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R7
  AST_SET_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !flag) |=> !flag); // R12
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !bus_valid) |=> !brk_flag); // R7
  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> brk_flag); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !flag) |=> !brk_irq); // R9
endmodule

// File: tb/bus_break_unit_tb_top.sv
module bus_break_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_sel = 0;
  logic cfg_wr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic bus_valid = 0, bus_word = 0, bus_write = 0, bus_fetch = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic brk_flag, brk_irq;

  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_break_unit dut_i (.clk, .rst_n, .cfg_sel, .cfg_wr, .cfg_wdata, .cfg_rdata,
    .bus_valid, .bus_addr, .bus_data, .bus_word, .bus_write, .bus_fetch,
    .brk_flag, .brk_irq);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); cfg_sel = s; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic reg_chk(string req, logic [1:0] s, logic [15:0] exp);
    @(negedge clk); cfg_sel = s; #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic access(string req, logic [15:0] a, logic [15:0] d, bit w, bit wr,
                        bit f, bit v, bit clear, bit ef, bit ei);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_word = w; bus_write = wr; bus_fetch = f;
    if (clear) begin cfg_sel = 2'd3; cfg_wdata = 16'h0; cfg_wr = 1; end
    @(posedge clk);
    exp_q.push_back({ef, ei}); tag_q.push_back(req);
    @(negedge clk);
    bus_valid = 0; cfg_wr = 0;
  endtask

  task automatic clear_flag();
    reg_wr(2'd3, 16'h0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check({t, " flag"}, {15'd0, brk_flag}, {15'd0, e[1]});
        check({t, " irq"}, {15'd0, brk_irq}, {15'd0, e[0]});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag", {15'd0, brk_flag}, 16'd0);
    check("R1 irq", {15'd0, brk_irq}, 16'd0);
    rst_n = 1;
    reg_chk("R1 addr", 2'd0, 16'hFFFF);
    reg_chk("R1 ctrl", 2'd2, 16'h0);
    reg_chk("R1 status", 2'd3, 16'h0);

    reg_wr(2'd0, 16'h1234);
    reg_wr(2'd1, 16'hA55A);
    reg_wr(2'd2, 16'h0008);
    reg_chk("R10 addr", 2'd0, 16'h1234);
    reg_chk("R10 data", 2'd1, 16'hA55A);
    reg_chk("R10 ctrl", 2'd2, 16'h0008);

    // R11: flag not visible before the sampling edge
    @(negedge clk);
    bus_valid = 1; bus_addr = 16'h1234; bus_fetch = 1; bus_word = 1;
    #1 check("R11 before edge", {15'd0, brk_flag}, 16'd0);
    @(posedge clk); #1 check("R11 after edge", {15'd0, brk_flag}, 16'd1);
    @(negedge clk); bus_valid = 0;
    reg_chk("R10 status", 2'd3, 16'h0001);
    clear_flag();

    access("R2 fetch hit", 16'h1234, 0, 1, 0, 1, 1, 0, 1, 1); clear_flag();
    access("R2 other addr", 16'h1235, 0, 1, 0, 1, 1, 0, 0, 0);
    access("R2 data read", 16'h1234, 0, 1, 0, 0, 1, 0, 0, 0);
    access("R12 no valid", 16'h1234, 0, 1, 0, 1, 0, 0, 0, 0);

    reg_wr(2'd3, 16'h0001);
    access("R7 write1 clear", 16'h0, 0, 1, 0, 0, 0, 0, 0, 0);
    access("R7 set", 16'h1234, 0, 1, 0, 1, 1, 0, 1, 1);
    reg_wr(2'd3, 16'h0001);
    access("R7 write1 set", 16'h0, 0, 1, 0, 0, 0, 0, 1, 1);
    access("R7 sticky", 16'h0, 0, 1, 0, 0, 0, 0, 1, 1);
    access("R8 clear+hit", 16'h1234, 0, 1, 0, 1, 1, 1, 1, 1);
    access("R7 cleared", 16'h0, 0, 1, 0, 0, 0, 1, 0, 0);

    reg_wr(2'd2, 16'h0009);
    access("R3 read hit", 16'h1234, 0, 1, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R3 read kind write", 16'h1234, 0, 1, 1, 0, 1, 0, 0, 0);
    reg_wr(2'd2, 16'h000A);
    access("R3 write hit", 16'h1234, 0, 1, 1, 0, 1, 0, 1, 1); clear_flag();
    access("R3 write kind read", 16'h1234, 0, 1, 0, 0, 1, 0, 0, 0);
    reg_wr(2'd2, 16'h000B);
    access("R3 rw read", 16'h1234, 0, 0, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R3 rw write", 16'h1234, 0, 0, 1, 0, 1, 0, 1, 1); clear_flag();
    access("R3 rw fetch", 16'h1234, 0, 1, 0, 1, 1, 0, 0, 0);
    access("R4 no dce any data", 16'h1234, 16'h0000, 1, 0, 0, 1, 0, 1, 1); clear_flag();

    reg_wr(2'd2, 16'h000F);
    access("R5 byte even hit", 16'h1234, 16'hA500, 0, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R5 byte lower ignored", 16'h1234, 16'hA5FF, 0, 1, 0, 1, 0, 1, 1); clear_flag();
    access("R5 byte lower lane", 16'h1234, 16'h005A, 0, 0, 0, 1, 0, 0, 0);
    access("R6 word even hit", 16'h1234, 16'hA55A, 1, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R6 word even half", 16'h1234, 16'hA500, 1, 0, 0, 1, 0, 0, 0);
    reg_wr(2'd0, 16'h1235);
    access("R5 byte odd hit", 16'h1235, 16'hA500, 0, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R6 word odd hit", 16'h1235, 16'hFF5A, 1, 0, 0, 1, 0, 1, 1); clear_flag();
    access("R6 word odd upper", 16'h1235, 16'hA500, 1, 0, 0, 1, 0, 0, 0);

    reg_wr(2'd2, 16'h0007);
    access("R9 ie off", 16'h1235, 16'h005A, 1, 0, 0, 1, 0, 1, 0);
    reg_wr(2'd2, 16'h000F);
    access("R9 ie on", 16'h0, 0, 1, 0, 0, 0, 0, 1, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule